// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers eight interrupt request lines, decides which one should be served, and signals the host over a single interrupt output. The host programs it through a byte-wide port with a single address bit. First comes a short initialization sequence of command words. After that, operational commands manage masking, end-of-interrupt handling, priority rotation and read-back. When the host acknowledges, the block presents a vector made from a programmed base and the winning line number. It then marks that line as in service, so that equal and lower lines are held off until software retires it.

Requests are latched either on a rising edge or followed as levels. Priority starts in a fixed order and can be rotated. A poll read can replace the acknowledge cycle. An automatic end-of-interrupt mode lets the block run without retire commands. The cascade word of the initialization sequence is accepted and discarded, because only single-controller operation is built.

Top module: `pic8_core`

## Requirements
- R1: Reset, or any write to address 0 with data bit 4 set, clears the mask, in-service and request registers. It returns priority to fixed order (line 0 highest, line 7 lowest), selects request read-back, disarms any pending poll and clears the automatic-EOI and same-level-nesting modes.
- R2: After that start word, the following address-1 writes are taken in this order. The base word comes first, and its data[7:3] is the vector base. The cascade word comes next and is skipped when start-word bit 1 is 1. The mode word comes last and is skipped when start-word bit 0 is 0; a skipped mode word leaves bit 1 (automatic EOI) and bit 4 (same-level nesting) at 0. Start-word bit 3 picks level (1) or edge (0) triggering.
- R3: Once initialization is done, an address-1 write loads the mask (bit n blocks line n), and an address-1 read returns it. A masked line never raises int_o, but its request stays latched and is served after unmasking.
- R4: In edge mode a request is latched on a 0-to-1 change of its line and cleared by its acknowledge. A line that stays high makes no new request. A line already high at reset or at the start word must fall and rise again.
- R5: In level mode the request register follows the lines one clock later, and a line still high after its end-of-interrupt requests again at once.
- R6: int_o is high when the highest-priority unmasked request outranks the highest-priority in-service line.
- R7: While inta is high, vec_o = {base, winning line}. The acknowledge edge sets that in-service bit and clears its edge latch. With no request, vec_o gives line 7 and nothing is set.
- R8: An address-0 write with bits 4 and 3 clear is a control command decoded from bits 7:5. Code 001 clears the highest-priority in-service bit. Code 011 clears the in-service bit named by bits 2:0.
- R9: Code 101 clears the highest-priority in-service bit and makes that line the lowest priority. Code 111 clears the named bit and makes the named line lowest. Code 110 only makes the named line lowest. Priority then runs upward from the line after the lowest, wrapping past 7.
- R10: An address-0 write with bit 4 clear and bit 3 set is a mode command. When its bit 1 is 1, bit 0 chooses what address-0 reads return: in-service (1) or request (0).
- R11: A mode command with bit 2 set arms a poll. The next address-0 read with rd_en returns {pending, 0000, line}, or 0x00 when nothing would raise int_o. That read acknowledges the line as in R7, and reads after it return the selected register again.
- R12: With automatic EOI (mode-word bit 1), an acknowledge leaves the in-service register unchanged.
- R13: A mode command with bits 6 and 5 set enables special masking, and bits 6 set with 5 clear disables it. While it is enabled, masked in-service lines do not hold off other requests.
- R14: With same-level nesting (mode-word bit 4), a request on the line currently highest in service raises int_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for poll reads) |
| addr | input | 1 | Register port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge strobe, one clock per acknowledge |
| int_o | output | 1 | Interrupt to host |
| vec_o | output | 8 | Vector presented during acknowledge |

## Verification
Register writes, acknowledges and poll reads take effect at the clock edge that samples them. int_o, rdata and vec_o are combinational from the registers, so their new values are due at the next falling edge, and the bench reads them there. A request line change needs one edge to enter the request register, so int_o is checked one full clock after the line is driven. vec_o and poll data are captured just after the strobe rises, before the edge that changes the in-service state.

// File: rtl/pic8_core.sv
module pic8_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  input  logic       inta,
  output logic       int_o,
  output logic [7:0] vec_o
);
  localparam int LW = 3;

  typedef enum logic [1:0] {READY, W_BASE, W_CASC, W_MODE} seq_t;

  seq_t          st;
  logic [7:3]    base;
  logic          single, need_mode, ltim, aeoi, sfnm, smm, read_is, poll;
  logic [7:0]    mask, isr, irr, prev;
  logic [LW-1:0] lowest;

  function automatic logic [LW:0] pick(input logic [7:0] v, input logic [LW-1:0] low);
    logic [LW-1:0] l;
    pick = {1'b0, 3'd7};
    for (int i = 7; i >= 0; i--) begin
      l = low + LW'(i) + 3'd1;
      if (v[l]) pick = {1'b1, l};
    end
  endfunction

  logic [7:0]    pend, isr_eff;
  logic          wf, sf, tf, grant, ready, poll_rd, ack_hit;
  logic [LW-1:0] wl, sl, tl, wrank, srank;

  assign ready   = (st == READY);
  assign pend    = irr & ~mask;
  assign isr_eff = smm ? (isr & ~mask) : isr;
  assign {wf, wl} = pick(pend, lowest);
  assign {sf, sl} = pick(isr_eff, lowest);
  assign {tf, tl} = pick(isr, lowest);
  assign wrank   = wl - lowest - 3'd1;
  assign srank   = sl - lowest - 3'd1;
  assign grant   = ready && wf && (!sf || wrank < srank || (sfnm && wrank == srank));
  assign int_o   = grant;
  assign vec_o   = {base, wl};
  assign poll_rd = rd_en && !addr && poll;
  assign ack_hit = (inta || poll_rd) && grant;

  assign rdata = addr ? mask :
                 poll ? {grant, 4'b0000, grant ? wl : 3'd0} :
                 read_is ? isr : irr;

  logic start_w, ctl_w, mode_w;
  assign start_w = wr_en && !addr && wdata[4];
  assign ctl_w   = wr_en && !addr && !wdata[4] && !wdata[3] && ready;
  assign mode_w  = wr_en && !addr && !wdata[4] &&  wdata[3] && ready;

  logic [7:0] isr_nx, irr_nx, ack_bit;
  assign ack_bit = ack_hit ? (8'h01 << wl) : 8'h00;

  always_comb begin
    isr_nx = isr;
    if (ack_hit && !aeoi) isr_nx = isr_nx | ack_bit;
    if (ctl_w && wdata[5]) begin
      if (wdata[6])  isr_nx[wdata[2:0]] = 1'b0;
      else if (tf)   isr_nx[tl] = 1'b0;
    end
  end

  always_comb begin
    if (ltim) irr_nx = irq_in;
    else      irr_nx = (irr | (irq_in & ~prev)) & ~ack_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= READY; base <= '0; single <= 1'b1; need_mode <= 1'b0;
      ltim <= 1'b0; aeoi <= 1'b0; sfnm <= 1'b0; smm <= 1'b0;
      read_is <= 1'b0; poll <= 1'b0;
      mask <= '0; isr <= '0; irr <= '0; prev <= '1; lowest <= 3'd7;
    end else if (start_w) begin
      st <= W_BASE; single <= wdata[1]; need_mode <= wdata[0]; ltim <= wdata[3];
      aeoi <= 1'b0; sfnm <= 1'b0; smm <= 1'b0; read_is <= 1'b0; poll <= 1'b0;
      mask <= '0; isr <= '0; irr <= '0; prev <= '1; lowest <= 3'd7;
    end else begin
      prev <= irq_in;
      irr  <= irr_nx;
      isr  <= isr_nx;
      if (poll_rd) poll <= 1'b0;
      if (wr_en && addr) begin
        unique case (st)
          W_BASE: begin
            base <= wdata[7:3];
            st   <= !single ? W_CASC : (need_mode ? W_MODE : READY);
          end
          W_CASC: st <= need_mode ? W_MODE : READY;
          W_MODE: begin
            aeoi <= wdata[1];
            sfnm <= wdata[4];
            st   <= READY;
          end
          default: mask <= wdata;
        endcase
      end
      if (ctl_w) begin
        unique case (wdata[7:5])
          3'b101:          if (tf) lowest <= tl;
          3'b110, 3'b111:  lowest <= wdata[2:0];
          default: ;
        endcase
      end
      if (mode_w) begin
        if (wdata[2]) poll <= 1'b1;
        if (wdata[1]) read_is <= wdata[0];
        if (wdata[6]) smm <= wdata[5];
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (mask == 8'h00 && isr == 8'h00 && irr == 8'h00)) else $error("start word"); // R1
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && ready) |=> rdata == $past(wdata) || !addr) else $error("mask load"); // R3
  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> |(irr & ~mask)) else $error("int without request"); // R6
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_o && !aeoi && !wr_en) |=> isr[$past(wl)]) else $error("ack"); // R7
  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && inta && !wr_en && !rd_en) |=> $stable(isr)) else $error("aeoi"); // R12
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ltim && !wr_en) |=> irr == $past(irq_in)) else $error("level"); // R5
endmodule

// File: tb/tb_pic8_core.sv
module tb_pic8_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = 8'h00, irq = 8'h00;
  logic [7:0] rdata, vec_o;
  logic       int_o;
  int checks = 0, errs = 0;

  pic8_core dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq_in(irq), .inta(inta),
                 .int_o(int_o), .vec_o(vec_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask
  task automatic chk_int(string tag, logic exp);
    chk(tag, {7'b0, int_o}, {7'b0, exp});
  endtask
  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic ack(output logic [7:0] v);
    @(negedge clk); inta = 1'b1; #1 v = vec_o;
    @(negedge clk); inta = 1'b0;
  endtask
  task automatic lines(logic [7:0] v);
    @(negedge clk); irq = v; @(negedge clk);
  endtask
  task automatic init(logic [7:0] w1, logic [7:0] w2, logic [7:0] w3, logic [7:0] w4);
    wr(1'b0, w1); wr(1'b1, w2);
    if (!w1[1]) wr(1'b1, w3);
    if (w1[0])  wr(1'b1, w4);
  endtask
  task automatic rd_isr(output logic [7:0] d);
    wr(1'b0, 8'h0B); rd(1'b0, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b1, d); chk("R1 mask at reset", d, 8'h00);
    rd(1'b0, d); chk("R1 request reg at reset", d, 8'h00);
    chk_int("R1 int at reset", 1'b0);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    init(8'h13, 8'h4D, 8'h00, 8'h01);
    wr(1'b1, 8'hA5); rd(1'b1, d); chk("R3 mask readback", d, 8'hA5);
    wr(1'b1, 8'h00);
    lines(8'h08); chk_int("R4 rising edge", 1'b1);
    ack(d); chk("R2 R7 vector base|3", d, 8'h4B);
    chk_int("R7 int after ack", 1'b0);
    rd_isr(d); chk("R10 in-service read", d, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R7 edge latch cleared", d, 8'h00);
    wr(1'b0, 8'h20); chk_int("R4 held line no re-request", 1'b0);
    rd_isr(d); chk("R8 nonspecific eoi", d, 8'h00);
    lines(8'h00); lines(8'h08); chk_int("R4 new edge", 1'b1);
    ack(d); chk("R7 second ack", d, 8'h4B);
    wr(1'b0, 8'h63); rd(1'b0, d); chk("R8 specific eoi", d, 8'h00);
    ack(d); chk("R7 spurious vector", d, 8'h4F);
    rd(1'b0, d); chk("R7 spurious leaves isr", d, 8'h00);
    lines(8'h00);
  endtask

  task automatic t_prio;
    logic [7:0] d;
    lines(8'h24); chk_int("R6 request", 1'b1);
    ack(d); chk("R6 line 2 beats 5", d, 8'h4A);
    chk_int("R6 lower blocked", 1'b0);
    lines(8'h26); chk_int("R6 higher nests", 1'b1);
    ack(d); chk("R7 line 1 vector", d, 8'h49);
    rd_isr(d); chk("R7 two in service", d, 8'h06);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R8 clears highest", d, 8'h04);
    wr(1'b0, 8'h62); chk_int("R8 specific frees line 5", 1'b1);
    ack(d); chk("R6 line 5 vector", d, 8'h4D);
    wr(1'b0, 8'h20); lines(8'h00);
    wr(1'b1, 8'h10); lines(8'h10); chk_int("R3 masked line", 1'b0);
    wr(1'b1, 8'h00); chk_int("R3 served after unmask", 1'b1);
    ack(d); chk("R3 vector after unmask", d, 8'h4C);
    wr(1'b0, 8'h20); lines(8'h00);
  endtask

  task automatic t_rotate;
    logic [7:0] d;
    lines(8'h01); ack(d); chk("R9 line 0 first", d, 8'h48);
    wr(1'b0, 8'hA0); rd_isr(d); chk("R9 rotate eoi clears", d, 8'h00);
    lines(8'h00); lines(8'h81);
    ack(d); chk("R9 line 7 beats 0 after rotate", d, 8'h4F);
    chk_int("R9 line 0 now lowest", 1'b0);
    wr(1'b0, 8'h20); ack(d); chk("R9 line 0 served", d, 8'h48);
    wr(1'b0, 8'h20); lines(8'h00);
    wr(1'b0, 8'hC7);
    lines(8'h48); ack(d); chk("R9 fixed order restored", d, 8'h4B);
    wr(1'b0, 8'hE3); rd_isr(d); chk("R9 specific rotate clears", d, 8'h00);
    lines(8'h4C); ack(d); chk("R9 line 6 beats 2", d, 8'h4E);
    wr(1'b0, 8'h20); wr(1'b0, 8'hC7);
    ack(d); chk("R9 set priority only", d, 8'h4A);
    wr(1'b0, 8'h20); lines(8'h00);
  endtask

  task automatic t_poll;
    logic [7:0] d;
    lines(8'h40); wr(1'b0, 8'h0C);
    rd(1'b0, d); chk("R11 poll byte", d, 8'h86);
    chk_int("R11 poll acknowledges", 1'b0);
    rd(1'b0, d); chk("R11 read after poll", d, 8'h40);
    wr(1'b0, 8'h20); lines(8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, d); chk("R11 empty poll", d, 8'h00);
  endtask

  task automatic t_smm;
    logic [7:0] d;
    lines(8'h04); ack(d); chk("R13 line 2 served", d, 8'h4A);
    lines(8'h24); wr(1'b1, 8'h04); chk_int("R13 blocked without smm", 1'b0);
    wr(1'b0, 8'h68); chk_int("R13 smm lets line 5 in", 1'b1);
    ack(d); chk("R13 line 5 vector", d, 8'h4D);
    wr(1'b0, 8'h48); wr(1'b0, 8'h65); wr(1'b0, 8'h62); wr(1'b1, 8'h00);
    rd_isr(d); chk("R8 all retired", d, 8'h00);
    lines(8'h00);
  endtask

  task automatic t_aeoi;
    logic [7:0] d;
    init(8'h13, 8'h48, 8'h00, 8'h03);
    lines(8'h02); ack(d); chk("R12 vector", d, 8'h49);
    rd_isr(d); chk("R12 isr untouched", d, 8'h00);
    lines(8'h00);
  endtask

  task automatic t_skip;
    logic [7:0] d;
    wr(1'b0, 8'h12); wr(1'b1, 8'h20);
    wr(1'b1, 8'h0F); rd(1'b1, d); chk("R2 short sequence", d, 8'h0F);
    wr(1'b1, 8'h00);
    lines(8'h02); ack(d); chk("R2 new base", d, 8'h21);
    rd_isr(d); chk("R2 skipped mode clears aeoi", d, 8'h02);
    wr(1'b0, 8'h20); lines(8'h00);
    init(8'h11, 8'h88, 8'h04, 8'h01);
    wr(1'b1, 8'h3C); rd(1'b1, d); chk("R2 cascade sequence", d, 8'h3C);
    lines(8'h01); ack(d); chk("R2 cascade base", d, 8'h88);
  endtask

  task automatic t_restart;
    logic [7:0] d;
    wr(1'b0, 8'hC0);
    wr(1'b0, 8'h13); rd(1'b1, d); chk("R1 start clears mask", d, 8'h00);
    wr(1'b1, 8'h48); wr(1'b1, 8'h01);
    rd_isr(d); chk("R1 start clears isr", d, 8'h00);
    chk_int("R4 held line ignored after start", 1'b0);
    lines(8'h00); lines(8'h81);
    ack(d); chk("R1 fixed order after start", d, 8'h48);
    wr(1'b0, 8'h20); ack(d); chk("R1 line 7 next", d, 8'h4F);
    wr(1'b0, 8'h20); lines(8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d;
    init(8'h1B, 8'h48, 8'h00, 8'h01);
    lines(8'h10); chk_int("R5 level request", 1'b1);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R5 request reg", d, 8'h10);
    lines(8'h00); chk_int("R5 level dropped", 1'b0);
    lines(8'h10); ack(d); chk("R5 vector", d, 8'h4C);
    wr(1'b0, 8'h20); chk_int("R5 still high re-requests", 1'b1);
    lines(8'h00); chk_int("R5 released", 1'b0);
  endtask

  task automatic t_sfnm;
    logic [7:0] d;
    init(8'h13, 8'h48, 8'h00, 8'h11);
    lines(8'h08); ack(d); chk("R14 first", d, 8'h4B);
    lines(8'h00); lines(8'h08); chk_int("R14 same level nests", 1'b1);
    ack(d); chk("R14 second", d, 8'h4B);
    wr(1'b0, 8'h20); lines(8'h00);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errs++;
    $display("FAIL watchdog R1 got timeout exp completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_edge();
    t_prio();
    t_rotate();
    t_poll();
    t_smm();
    t_aeoi();
    t_skip();
    t_restart();
    t_level();
    t_sfnm();
    finish_run();
  end
endmodule